// File: doc/BRIEF.md
# Two-Channel Bus Master Register Block

This block holds the software-visible control state of a two-channel DMA engine that moves 16-bit words between a drive channel and memory. Software reaches it through an I/O window of sixteen bytes. The lower eight bytes belong to channel 0 and the upper eight bytes belong to channel 1. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. A 32-bit register bus reaches them through four byte enables, with one enable for each byte lane.

The block claims an access only when the configured window base is nonzero, I/O decoding is enabled and the address falls inside the window. It gives the DMA engine the following per-channel values: a one-cycle start pulse, the transfer direction, the active flag, the descriptor pointer and a working memory address. The DMA engine reports back with three events: transfer-done, error and address-step. Each drive channel's interrupt request passes straight through the block and also latches a status flag.

All pins are plain level or pulse signals. Register accesses complete in a single cycle and read data is combinational, so the edge has no handshake and no back-pressure.

Top module: `busmaster_regs`

## Requirements
- R1: An access is claimed (`bus_hit`=1) only when `bus_rd` or `bus_wr` is high, `cfg_io_en`=1, the window base `{cfg_base[15:4],4'h0}` is nonzero, and `bus_addr[15:4]` equals `cfg_base[15:4]`. Bits 3:0 of `cfg_base` are ignored.
- R2: Within a channel, byte offset 0 is the command register, and only its bit 0 (start) and bit 3 (direction, output on `dir`) can be written. A write of 0xFF therefore reads back as 0x09.
- R3: Every command write copies the written start bit into status bit 0 (`dma_active`). A start bit that goes from 0 to 1 gives a one-cycle `start_pulse` in the cycle after the write. Writing start=1 again while it is already 1 gives no pulse.
- R4: Status sits at byte offset 2. Its bits 7, 4 and 3 always read 0. Bits 6:5 can be read and written. A write cannot change bit 0.
- R5: A rising edge on `irq_in[c]` sets status bit 2 one cycle later. `irq_out[c]` follows `irq_in[c]` with no delay.
- R6: Status bits 2 (interrupt) and 1 (error) are cleared by writing a 1 to them and are kept when a 0 is written. An `err_ev[c]` pulse sets bit 1. A set event in the same cycle as a clearing write takes priority.
- R7: A `done_ev[c]` pulse clears status bit 0 and leaves the command start bit unchanged. A command write in the same cycle takes priority.
- R8: Byte offsets 4–7 hold the descriptor pointer, least significant byte first, and its bits 1:0 always read 0. Every pointer byte write loads `work_addr` with the complete new pointer value.
- R9: Each `step[c]` pulse with no pointer write in the same cycle adds 2 to that channel's `work_addr`.
- R10: Address bit 3 selects the channel (0: channel 0, 1: channel 1). A write to one channel leaves the other channel's registers unchanged.
- R11: Byte offsets 1 and 3 are undefined. Reads of them return 0x00 on their lane, and writes to them have no effect.
- R12: A write that is not claimed changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 16 | I/O window base (bits 3:0 ignored) |
| cfg_io_en | input | 1 | I/O decode enable from configuration |
| bus_addr | input | 16 | Access address; bits 1:0 are taken as 0 |
| bus_be | input | 4 | Byte enables; lane i is offset {addr[2],i} |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; lanes with no enable, or with no claim, are 0 |
| bus_hit | output | 1 | Access claimed by this block |
| irq_in | input | 2 | Interrupt request from each drive channel |
| irq_out | output | 2 | Interrupt request passed through |
| err_ev | input | 2 | Error event from the DMA engine |
| done_ev | input | 2 | Transfer-done event from the DMA engine |
| step | input | 2 | Word-transferred event; advances the working address |
| start_pulse | output | 2 | One-cycle start request to the DMA engine |
| dir | output | 2 | Transfer direction bit from the command register |
| dma_active | output | 2 | Status bit 0 of each channel |
| desc_ptr | output | 64 | Descriptor pointers; channel c is bits [32c+31:32c] |
| work_addr | output | 64 | Working memory addresses; channel c is bits [32c+31:32c] |

## Verification
The decode is tried with I/O decoding disabled, with a zero base, with a base whose low bits are set, and with addresses one below the window, one above it and at its last byte. This separates the three terms of the claim condition from the window comparison.

Command writes use the values 0xFF, 0x01 and then 0x09 again. This separates the start edge from the start level and shows the masking of the command byte. Status writes alternate between patterns with zeros and with ones in the flag bits, so clear-on-one can be told apart from plain storage.

Pointer writes mix full-word and single-byte enables. This checks the lane-to-byte order and the alignment mask. Byte-enable patterns that touch only the undefined offsets, and writes to channel 1, then confirm that nothing leaks between offsets or between channels.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // byte offsets inside one channel's eight-byte slice
  localparam logic [2:0] OFF_CMD   = 3'd0;
  localparam logic [2:0] OFF_STS   = 3'd2;
  localparam logic [2:0] OFF_PTR0  = 3'd4;
  // command: start is bit 0, direction bit 3
  localparam int         CMD_START = 0;
  localparam int         CMD_DIR   = 3;
  localparam logic [7:0] CMD_MASK  = 8'h09;
  // status fields
  localparam int         STS_ACT   = 0;
  localparam int         STS_ERR   = 1;
  localparam int         STS_IRQ   = 2;
  localparam logic [7:0] STS_RW    = 8'h60;
endpackage

// File: rtl/bmr_decode.sv
module bmr_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              io_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_W;

  logic [TAG_W-1:0] base_tag;
  assign base_tag = base[ADDR_W-1:WIN_W];

  always_comb begin
    hit = acc && io_en && (base_tag != '0) && (addr[ADDR_W-1:WIN_W] == base_tag);
  end
endmodule

// File: rtl/bmr_channel.sv
module bmr_channel
  import bmr_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bw,
  input  logic [7:0][7:0]  bdat,
  input  logic             irq_in,
  input  logic             err_ev,
  input  logic             done_ev,
  input  logic             step,
  output logic [7:0]       cmd_q,
  output logic [7:0]       sts_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] waddr_q,
  output logic             start_pulse
);
  localparam int PB = PTR_W / 8;

  logic             irq_d;
  logic             irq_rise;
  logic [7:0]       sts_nxt;
  logic [PTR_W-1:0] ptr_nxt;
  logic             ptr_wr;

  assign irq_rise = irq_in && !irq_d;

  always_comb begin
    sts_nxt = sts_q;
    if (bw[OFF_CMD])      sts_nxt[STS_ACT] = bdat[OFF_CMD][CMD_START];
    else if (done_ev)     sts_nxt[STS_ACT] = 1'b0;
    if (bw[OFF_STS]) begin
      sts_nxt[6:5] = bdat[OFF_STS][6:5];
      if (bdat[OFF_STS][STS_IRQ]) sts_nxt[STS_IRQ] = 1'b0;
      if (bdat[OFF_STS][STS_ERR]) sts_nxt[STS_ERR] = 1'b0;
    end
    if (irq_rise) sts_nxt[STS_IRQ] = 1'b1;
    if (err_ev)   sts_nxt[STS_ERR] = 1'b1;
    sts_nxt[7]   = 1'b0;
    sts_nxt[4:3] = 2'b00;
  end

  always_comb begin
    ptr_nxt = ptr_q;
    ptr_wr  = 1'b0;
    for (int k = 0; k < PB; k++) begin
      if (bw[OFF_PTR0 + k]) begin
        ptr_nxt[8*k +: 8] = bdat[OFF_PTR0 + k];
        ptr_wr = 1'b1;
      end
    end
    ptr_nxt[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      sts_q       <= '0;
      ptr_q       <= '0;
      waddr_q     <= '0;
      irq_d       <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      irq_d       <= irq_in;
      sts_q       <= sts_nxt;
      ptr_q       <= ptr_nxt;
      start_pulse <= bw[OFF_CMD] && bdat[OFF_CMD][CMD_START] && !cmd_q[CMD_START];
      if (bw[OFF_CMD]) cmd_q <= bdat[OFF_CMD] & CMD_MASK;
      if (ptr_wr)      waddr_q <= ptr_nxt;
      else if (step)   waddr_q <= waddr_q + PTR_W'(2);
    end
  end
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32,
  parameter int NCH    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     cfg_base,
  input  logic                  cfg_io_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_hit,
  input  logic [NCH-1:0]        irq_in,
  output logic [NCH-1:0]        irq_out,
  input  logic [NCH-1:0]        err_ev,
  input  logic [NCH-1:0]        done_ev,
  input  logic [NCH-1:0]        step,
  output logic [NCH-1:0]        start_pulse,
  output logic [NCH-1:0]        dir,
  output logic [NCH-1:0]        dma_active,
  output logic [NCH*PTR_W-1:0]  desc_ptr,
  output logic [NCH*PTR_W-1:0]  work_addr
);
  localparam int NB    = DATA_W / 8;
  localparam int WIN_W = 4;

  logic [7:0]       cmd_q [NCH];
  logic [7:0]       sts_q [NCH];
  logic [PTR_W-1:0] ptr_q [NCH];
  logic [7:0][7:0]  bdat;
  logic             ch_sel;

  assign ch_sel  = bus_addr[3];
  assign irq_out = irq_in;

  bmr_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
    .base (cfg_base),
    .io_en(cfg_io_en),
    .addr (bus_addr),
    .acc  (bus_rd | bus_wr),
    .hit  (bus_hit)
  );

  always_comb begin
    for (int l = 0; l < 8; l++) bdat[l] = bus_wdata[8*(l % NB) +: 8];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]       bw;
    logic [PTR_W-1:0] waddr;

    always_comb begin
      for (int l = 0; l < 8; l++) begin
        bw[l] = bus_wr && bus_hit && (ch_sel == c[0]) &&
                (bus_addr[2] == l[2]) && bus_be[l % NB];
      end
    end

    bmr_channel #(.PTR_W(PTR_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .bw         (bw),
      .bdat       (bdat),
      .irq_in     (irq_in[c]),
      .err_ev     (err_ev[c]),
      .done_ev    (done_ev[c]),
      .step       (step[c]),
      .cmd_q      (cmd_q[c]),
      .sts_q      (sts_q[c]),
      .ptr_q      (ptr_q[c]),
      .waddr_q    (waddr),
      .start_pulse(start_pulse[c])
    );

    assign dir[c]                    = cmd_q[c][CMD_DIR];
    assign dma_active[c]             = sts_q[c][STS_ACT];
    assign desc_ptr[c*PTR_W +: PTR_W]  = ptr_q[c];
    assign work_addr[c*PTR_W +: PTR_W] = waddr;
  end

  always_comb begin
    logic [2:0] loc;
    bus_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      loc = {bus_addr[2], i[1:0]};
      if (bus_rd && bus_hit && bus_be[i]) begin
        if (loc == OFF_CMD)       bus_rdata[8*i +: 8] = cmd_q[ch_sel];
        else if (loc == OFF_STS)  bus_rdata[8*i +: 8] = sts_q[ch_sel];
        else if (loc[2])          bus_rdata[8*i +: 8] = ptr_q[ch_sel][8*loc[1:0] +: 8];
      end
    end
  end
endmodule

// File: rtl/busmaster_regs_chk.sv
module busmaster_regs_chk #(
  parameter int NCH   = 2,
  parameter int PTR_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_hit,
  input logic                 cfg_io_en,
  input logic [15:0]          cfg_base,
  input logic [NCH-1:0]       irq_in,
  input logic [NCH-1:0]       done_ev,
  input logic [NCH-1:0]       start_pulse,
  input logic [NCH-1:0]       dma_active,
  input logic [NCH*PTR_W-1:0] desc_ptr,
  input logic [7:0]           sts0,
  input logic [7:0]           sts1
);
  // R1
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> (cfg_io_en && cfg_base[15:4] != 12'h0));

  // R4
  sts_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts0 & 8'h98) == 8'h00) && ((sts1 & 8'h98) == 8'h00));

  // R12
  unclaimed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_hit) |=> $stable(desc_ptr));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> dma_active[c]);
    // R7
    done_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ev[c] && !bus_wr) |=> !dma_active[c]);
    // R8
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ptr[c*PTR_W +: 2] == 2'b00);
  end

  // R5
  irq0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_in[0]) |=> sts0[2]);
  // R5
  irq1_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_in[1]) |=> sts1[2]);
endmodule

bind busmaster_regs busmaster_regs_chk #(.NCH(NCH), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_hit    (bus_hit),
  .cfg_io_en  (cfg_io_en),
  .cfg_base   (cfg_base),
  .irq_in     (irq_in),
  .done_ev    (done_ev),
  .start_pulse(start_pulse),
  .dma_active (dma_active),
  .desc_ptr   (desc_ptr),
  .sts0       (sts_q[0]),
  .sts1       (sts_q[1])
);

// File: tb/busmaster_regs_tb_top.sv
module busmaster_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cfg_base = 16'hC000;
  logic        cfg_io_en = 1;
  logic [15:0] bus_addr = 0;
  logic [3:0]  bus_be = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bus_hit;
  logic [1:0]  irq_in = 0, irq_out, err_ev = 0, done_ev = 0, step = 0;
  logic [1:0]  start_pulse, dir, dma_active;
  logic [63:0] desc_ptr, work_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  busmaster_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_io_en(cfg_io_en),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
    .irq_in(irq_in), .irq_out(irq_out), .err_ev(err_ev), .done_ev(done_ev),
    .step(step), .start_pulse(start_pulse), .dir(dir), .dma_active(dma_active),
    .desc_ptr(desc_ptr), .work_addr(work_addr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
    #1;
  endtask

  // driver: pushes the expected read word, the monitor compares it
  task automatic bus_read(logic [15:0] a, logic [3:0] be, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_be = be; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0; bus_be = 0;
    #1;
  endtask

  task automatic probe_hit(logic [15:0] a, logic exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_be = 4'hF; bus_rd = 1;
    #1 chk(tag, bus_hit, exp);
    @(negedge clk);
    bus_rd = 0; bus_be = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (bus_rd && exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // reset state
    bus_read(16'hC000, 4'hF, 32'h0, "R2 reset cmd/sts");
    bus_read(16'hC004, 4'hF, 32'h0, "R8 reset ptr");
    chk("R3 reset pulse", start_pulse, 2'b00);

    // R1 decode
    cfg_io_en = 0;
    probe_hit(16'hC000, 0, "R1 io disabled");
    cfg_io_en = 1; cfg_base = 16'h0000;
    probe_hit(16'h0000, 0, "R1 zero base");
    cfg_base = 16'hC005;
    probe_hit(16'hC000, 1, "R1 base low bits ignored");
    probe_hit(16'hC00F, 1, "R1 last byte");
    probe_hit(16'hC010, 0, "R1 above window");
    probe_hit(16'hBFFF, 0, "R1 below window");
    cfg_base = 16'hC000;

    // R2/R3 command
    bus_write(16'hC000, 4'b0001, 32'hFF);
    chk("R3 start pulse", start_pulse, 2'b01);
    chk("R2 dir out", dir, 2'b01);
    idle(1);
    chk("R3 pulse one cycle", start_pulse, 2'b00);
    bus_read(16'hC000, 4'hF, 32'h0001_0009, "R2 cmd mask / R3 active copy");
    bus_write(16'hC000, 4'b0001, 32'h01);
    chk("R3 no pulse when already started", start_pulse, 2'b00);
    chk("R2 dir cleared", dir, 2'b00);
    bus_write(16'hC000, 4'b0001, 32'h09);
    chk("R3 no pulse on level", start_pulse, 2'b00);

    // R4 status
    bus_write(16'hC000, 4'b0100, 32'h00FE_0000);
    bus_read(16'hC000, 4'hF, 32'h0061_0009, "R4 reserved zero, bit0 read-only");

    // R5 / R6 interrupt flag
    @(negedge clk); irq_in[0] = 1; #1;
    chk("R5 irq passthrough", irq_out, 2'b01);
    idle(1);
    irq_in[0] = 0;
    bus_read(16'hC000, 4'b0100, 32'h0065_0000, "R5 irq latched");
    bus_write(16'hC000, 4'b0100, 32'h0060_0000);
    bus_read(16'hC000, 4'b0100, 32'h0065_0000, "R6 zero keeps irq flag");
    bus_write(16'hC000, 4'b0100, 32'h0064_0000);
    bus_read(16'hC000, 4'b0100, 32'h0061_0000, "R6 one clears irq flag");

    // R6 error flag
    @(negedge clk); err_ev[0] = 1;
    @(negedge clk); err_ev[0] = 0;
    bus_read(16'hC000, 4'b0100, 32'h0063_0000, "R6 error set");
    bus_write(16'hC000, 4'b0100, 32'h0062_0000);
    bus_read(16'hC000, 4'b0100, 32'h0061_0000, "R6 error cleared");

    // R7 done
    @(negedge clk); done_ev[0] = 1;
    @(negedge clk); done_ev[0] = 0; #1;
    chk("R7 active cleared", dma_active, 2'b00);
    bus_read(16'hC000, 4'hF, 32'h0060_0009, "R7 start bit kept");

    // R8 pointer, R9 step
    bus_write(16'hC004, 4'hF, 32'h1234_5677);
    bus_read(16'hC004, 4'hF, 32'h1234_5674, "R8 ptr aligned");
    chk("R8 work addr loaded", work_addr[31:0], 32'h1234_5674);
    bus_write(16'hC004, 4'b0010, 32'h0000_AB00);
    bus_read(16'hC004, 4'hF, 32'h1234_AB74, "R8 byte lane order");
    chk("R8 work addr reload", work_addr[31:0], 32'h1234_AB74);
    @(negedge clk); step[0] = 1;
    idle(2); step[0] = 0; #1;
    chk("R9 step advance", work_addr[31:0], 32'h1234_AB78);
    chk("R9 ptr unchanged by step", desc_ptr[31:0], 32'h1234_AB74);

    // R10 channel select
    bus_write(16'hC008, 4'b0001, 32'h01);
    chk("R10 ch1 pulse", start_pulse, 2'b10);
    bus_read(16'hC008, 4'hF, 32'h0001_0001, "R10 ch1 regs");
    bus_read(16'hC00C, 4'hF, 32'h0, "R10 ch1 ptr separate");
    bus_read(16'hC000, 4'hF, 32'h0060_0009, "R10 ch0 untouched");

    // R11 undefined offsets
    bus_write(16'hC000, 4'b1010, 32'hFFFF_FFFF);
    bus_read(16'hC000, 4'hF, 32'h0060_0009, "R11 undefined write ignored");
    bus_read(16'hC000, 4'b1010, 32'h0, "R11 undefined read zero");

    // R12 unclaimed write
    cfg_io_en = 0;
    bus_write(16'hC004, 4'hF, 32'hFFFF_FFFF);
    cfg_io_en = 1;
    bus_read(16'hC004, 4'hF, 32'h1234_AB74, "R12 unclaimed write ignored");

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule